// File: doc/BRIEF.md
# Serial Control Register Slave

This block is the control-port front end of an audio decoder. It connects to a two-wire serial bus of the I2C kind at speeds up to 400 kHz. The bus lines are sampled in the system clock domain, so the system clock must be much faster than the bus clock. A bus master writes five 8-bit control registers through the block. The registers hold the broadcast-standard select, the output routing bits, the two error-count thresholds used by an automatic mute elsewhere in the chip, and the mute and silence controls. A master read returns a status byte and a latched error count, both supplied by the surrounding logic.

The device address is 101101X. X is taken from a strap pin, so two of these blocks can share one bus. A write carries a register index first and then any number of data bytes. The index moves up by one after each data byte and goes from 4 back to 0. Two further straps set some register bits while reset is applied. The block never holds the clock low, and it only accepts 7-bit addresses.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 101101 followed by the level of `addr_sel`. With `addr_sel` low the write byte is B4h; with it high the write byte is B6h.
- R2: Any other address is not acknowledged, and that includes the all-zero general call. The block then ignores the bus until the next START.
- R3: After an acknowledged write address, the next byte is taken as the register index. Every later byte is stored in the indexed register. Each of these bytes is acknowledged by pulling `sda_oe` high while SCL is low and holding it through the ninth clock.
- R4: A register index above 04h is not acknowledged and changes no register.
- R5: The index goes up by one after each data byte and goes from 04h back to 00h. This lets a burst that starts at index 3 fill registers 3, 4, 0 and 1 in that order.
- R6: While reset is applied, bit 3 of register 1 (the silence bit, where 1 lets audio through) takes the level of `strap_mute_n`. A later write can set it to 1.
- R7: While reset is applied, bit 1 of register 0 takes the inverse of `strap_audio_n`. `gain_12db` always equals that bit: 1 selects 12 dB and 0 selects 6 dB.
- R8: `port_out` follows bit 3 of register 0.
- R9: A read address (the address byte with bit 0 set) returns `status_i` first, then `err_count_i`. The two keep alternating for as long as the master acknowledges, and a master NACK ends the transfer.
- R10: A STOP, or a repeated START, at any point ends the current transfer and returns the slave to waiting for an address. Registers already written keep their values.
- R11: After reset every register bit not set by a strap is 0, and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, sampled |
| sda_i | input | 1 | Bus data line, sampled |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| addr_sel | input | 1 | Strap that sets address bit 0 |
| strap_mute_n | input | 1 | Reset value of the silence bit |
| strap_audio_n | input | 1 | Inverse of the reset value of the gain bit |
| status_i | input | 8 | Status byte returned first on a read |
| err_count_i | input | 8 | Latched error count returned second on a read |
| mode_reg | output | 8 | Register 0: standard, gain, level match, port bit |
| route_reg | output | 8 | Register 1: source select, user mute, silence, FM attenuation |
| err_hi_lim | output | 8 | Register 2: upper error limit |
| err_lo_lim | output | 8 | Register 3: lower error limit |
| aux_reg | output | 8 | Register 4: auxiliary control byte |
| port_out | output | 1 | Direct output of register 0 bit 3 |
| gain_12db | output | 1 | Filter gain select taken from register 0 bit 1 |

## Verification
The assertions check on every cycle that the register index never leaves 0..4 and that it is 0 just after register 4 is written. They also check that the data line only changes while SCL is low, that a general call or an out-of-range index never draws an acknowledge, that a STOP always leaves the slave idle and released, and that the strap values appear when reset ends. The bench scenarios are needed for the rest: that whole bursts land in the right registers across the wrap, that reads alternate between the two input bytes, that a repeated START in the middle of a burst keeps earlier writes, and that an address with the wrong strap bit leaves the registers untouched.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int DATA_W   = 8;
    localparam int NUM_REGS = 5;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int LAST_IDX = NUM_REGS - 1;

    // Upper six bits of the device address; bit 0 comes from a strap.
    localparam logic [5:0] DEV_ADDR_HI = 6'b101101;

    // Register indices
    localparam int IDX_MODE  = 0;
    localparam int IDX_ROUTE = 1;

    // Bit positions inside the mode register
    localparam int MODE_BGH_BIT  = 0;
    localparam int MODE_GAIN_BIT = 1;
    localparam int MODE_LVL_BIT  = 2;
    localparam int MODE_PORT_BIT = 3;

    // Bit positions inside the route register
    localparam int ROUTE_MUTE_BIT = 2;
    localparam int ROUTE_SIL_BIT  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } bus_state_e;

    typedef struct packed {
        logic              we;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    function automatic logic [IDX_W-1:0] idx_next(input logic [IDX_W-1:0] cur);
        if (cur == IDX_W'(LAST_IDX))
            return '0;
        return cur + IDX_W'(1);
    endfunction

    function automatic logic [DATA_W-1:0] reset_value(input int idx,
                                                      input logic mute_n,
                                                      input logic audio_n);
        logic [DATA_W-1:0] v;
        v = '0;
        if (idx == IDX_MODE)
            v[MODE_GAIN_BIT] = ~audio_n;
        if (idx == IDX_ROUTE)
            v[ROUTE_SIL_BIT] = mute_n;
        return v;
    endfunction

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);
    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= 2'b11;
            hist_q  <= '1;
            level_o <= 1'b1;
            rise_o  <= 1'b0;
            fall_o  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], pin_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
            rise_o <= 1'b0;
            fall_o <= 1'b0;
            if ((&hist_q) && !level_o) begin
                level_o <= 1'b1;
                rise_o  <= 1'b1;
            end else if (!(|hist_q) && level_o) begin
                level_o <= 1'b0;
                fall_o  <= 1'b1;
            end
        end
    end

    assert_edge_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(rise_o && fall_o));

    assert_rise_level_R3: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> level_o);

endmodule

// File: rtl/i2cs_reg_bank.sv
module i2cs_reg_bank
    import i2cs_pkg::*;
(
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           strap_mute_n,
    input  logic                           strap_audio_n,
    input  reg_wr_t                        wr_i,
    output logic [NUM_REGS-1:0][DATA_W-1:0] regs_o
);
    for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_o[gi] <= reset_value(gi, strap_mute_n, strap_audio_n);
            else if (wr_i.we && (wr_i.idx == IDX_W'(gi)))
                regs_o[gi] <= wr_i.data;
        end
    end

    assert_silence_strap_R6: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs_o[IDX_ROUTE][ROUTE_SIL_BIT] == $past(strap_mute_n)));

    assert_gain_strap_R7: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs_o[IDX_MODE][MODE_GAIN_BIT] == !$past(strap_audio_n)));

    assert_idle_regs_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_i.we) |-> $stable(regs_o));

endmodule

// File: rtl/i2cs_bus_engine.sv
module i2cs_bus_engine
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              scl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda,
    input  logic              sda_rise,
    input  logic              sda_fall,
    input  logic              addr_lsb,
    input  logic [DATA_W-1:0] status_byte,
    input  logic [DATA_W-1:0] count_byte,
    output logic              sda_oe,
    output reg_wr_t           wr_o
);
    bus_state_e        st_q, nxt_q;
    logic [3:0]        cnt_q;
    logic [DATA_W-1:0] rx_q;
    logic [DATA_W-1:0] tx_q;
    logic [IDX_W-1:0]  idx_q;
    logic              cnt_sel_q;
    logic              macked_q;

    logic start_det, stop_det, byte_done, addr_hit;

    assign start_det = sda_fall && scl;
    assign stop_det  = sda_rise && scl;
    assign byte_done = scl_fall && (cnt_q == 4'd8);
    assign addr_hit  = (rx_q[7:1] == {DEV_ADDR_HI, addr_lsb});

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= ST_IDLE;
            nxt_q     <= ST_IDLE;
            cnt_q     <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            idx_q     <= '0;
            cnt_sel_q <= 1'b0;
            macked_q  <= 1'b0;
            sda_oe    <= 1'b0;
            wr_o      <= '0;
        end else begin
            wr_o.we <= 1'b0;
            if (start_det) begin
                st_q   <= ST_ADDR;
                cnt_q  <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                st_q   <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                unique case (st_q)
                    ST_ADDR, ST_SUB, ST_WDATA: begin
                        if (scl_rise && (cnt_q != 4'd8)) begin
                            rx_q  <= {rx_q[DATA_W-2:0], sda};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (byte_done) begin
                            cnt_q <= '0;
                            if (st_q == ST_ADDR) begin
                                if (addr_hit) begin
                                    sda_oe <= 1'b1;
                                    st_q   <= ST_ACK;
                                    if (rx_q[0]) begin
                                        nxt_q     <= ST_RDATA;
                                        tx_q      <= status_byte;
                                        cnt_sel_q <= 1'b1;
                                    end else begin
                                        nxt_q <= ST_SUB;
                                    end
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end else if (st_q == ST_SUB) begin
                                if (rx_q <= DATA_W'(LAST_IDX)) begin
                                    idx_q  <= rx_q[IDX_W-1:0];
                                    sda_oe <= 1'b1;
                                    st_q   <= ST_ACK;
                                    nxt_q  <= ST_WDATA;
                                end else begin
                                    st_q <= ST_IDLE;
                                end
                            end else begin
                                wr_o.we   <= 1'b1;
                                wr_o.idx  <= idx_q;
                                wr_o.data <= rx_q;
                                idx_q     <= idx_next(idx_q);
                                sda_oe    <= 1'b1;
                                st_q      <= ST_ACK;
                                nxt_q     <= ST_WDATA;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            cnt_q <= '0;
                            if (nxt_q == ST_RDATA)
                                sda_oe <= ~tx_q[DATA_W-1];
                            else
                                sda_oe <= 1'b0;
                            st_q <= nxt_q;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall) begin
                            if (cnt_q == 4'd7) begin
                                sda_oe <= 1'b0;
                                st_q   <= ST_RACK;
                            end else begin
                                tx_q   <= {tx_q[DATA_W-2:0], 1'b0};
                                sda_oe <= ~tx_q[DATA_W-2];
                                cnt_q  <= cnt_q + 4'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise)
                            macked_q <= ~sda;
                        else if (scl_fall) begin
                            if (macked_q) begin
                                tx_q      <= cnt_sel_q ? count_byte : status_byte;
                                sda_oe    <= cnt_sel_q ? ~count_byte[DATA_W-1]
                                                       : ~status_byte[DATA_W-1];
                                cnt_sel_q <= ~cnt_sel_q;
                                cnt_q     <= '0;
                                st_q      <= ST_RDATA;
                            end else begin
                                st_q <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_idx_range_R5: assert property (@(posedge clk) disable iff (rst)
        idx_q <= IDX_W'(LAST_IDX));

    assert_idx_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_o.we && (wr_o.idx == IDX_W'(LAST_IDX))) |-> (idx_q == '0));

    assert_no_gc_ack_R2: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ADDR && byte_done && !start_det && !stop_det && rx_q[7:1] == 7'd0)
        |=> !sda_oe);

    assert_bad_idx_nack_R4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SUB && byte_done && !start_det && !stop_det
         && rx_q > DATA_W'(LAST_IDX)) |=> (!sda_oe && st_q == ST_IDLE));

    assert_sda_scl_low_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> !$past(scl));

    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (stop_det && !start_det) |=> (st_q == ST_IDLE && !sda_oe));

endmodule

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave
    import i2cs_pkg::*;
#(
    parameter int FILT_LEN = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic       strap_mute_n,
    input  logic       strap_audio_n,
    input  logic [7:0] status_i,
    input  logic [7:0] err_count_i,
    output logic [7:0] mode_reg,
    output logic [7:0] route_reg,
    output logic [7:0] err_hi_lim,
    output logic [7:0] err_lo_lim,
    output logic [7:0] aux_reg,
    output logic       port_out,
    output logic       gain_12db
);
    logic scl_lvl, scl_rise, scl_fall;
    logic sda_lvl, sda_rise, sda_fall;
    reg_wr_t wr;
    logic [NUM_REGS-1:0][DATA_W-1:0] regs;

    i2cs_line_sync #(.FILT_LEN(FILT_LEN)) u_scl_sync (
        .clk(clk), .rst(rst), .pin_i(scl_i),
        .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
    );

    i2cs_line_sync #(.FILT_LEN(FILT_LEN)) u_sda_sync (
        .clk(clk), .rst(rst), .pin_i(sda_i),
        .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
    );

    i2cs_bus_engine u_engine (
        .clk(clk), .rst(rst),
        .scl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
        .addr_lsb(addr_sel),
        .status_byte(status_i), .count_byte(err_count_i),
        .sda_oe(sda_oe), .wr_o(wr)
    );

    i2cs_reg_bank u_regs (
        .clk(clk), .rst(rst),
        .strap_mute_n(strap_mute_n), .strap_audio_n(strap_audio_n),
        .wr_i(wr), .regs_o(regs)
    );

    assign mode_reg   = regs[0];
    assign route_reg  = regs[1];
    assign err_hi_lim = regs[2];
    assign err_lo_lim = regs[3];
    assign aux_reg    = regs[4];
    assign port_out   = regs[IDX_MODE][MODE_PORT_BIT];
    assign gain_12db  = regs[IDX_MODE][MODE_GAIN_BIT];

    assert_reset_release_R11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!sda_oe && err_hi_lim == 8'h00 && err_lo_lim == 8'h00
                        && aux_reg == 8'h00));

endmodule

// File: tb/i2c_ctrl_slave_bench.sv
module i2c_ctrl_slave_bench;

    typedef struct {
        string      tag;
        int         sel;
        logic [7:0] exp;
    } exp_item_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic addr_sel = 1'b0, strap_mute_n = 1'b0, strap_audio_n = 1'b0;
    logic [7:0] status_i = 8'hA5, err_count_i = 8'h3C;
    logic sda_oe, port_out, gain_12db;
    logic [7:0] mode_reg, route_reg, err_hi_lim, err_lo_lim, aux_reg;
    logic sda_bus;
    logic last_ack;
    logic [7:0] last_rd;
    int checks = 0, failures = 0;
    bit finished = 0;
    exp_item_t sb_q[$];

    localparam int Q = 20;

    always #5 clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    i2c_ctrl_slave u_i2c_ctrl_slave (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .strap_mute_n(strap_mute_n), .strap_audio_n(strap_audio_n),
        .status_i(status_i), .err_count_i(err_count_i),
        .mode_reg(mode_reg), .route_reg(route_reg), .err_hi_lim(err_hi_lim),
        .err_lo_lim(err_lo_lim), .aux_reg(aux_reg), .port_out(port_out),
        .gain_12db(gain_12db)
    );

    function automatic logic [7:0] observe(int sel);
        case (sel)
            0: return mode_reg;
            1: return route_reg;
            2: return err_hi_lim;
            3: return err_lo_lim;
            4: return aux_reg;
            5: return {7'd0, port_out};
            6: return {7'd0, gain_12db};
            7: return {7'd0, last_ack};
            8: return last_rd;
            default: return {7'd0, sda_oe};
        endcase
    endfunction

    // Monitor: pops expected items and compares with what the design shows.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_item_t it;
            logic [7:0] act;
            it = sb_q.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s sel=%0d actual=%02h expected=%02h", it.tag, it.sel, act, it.exp);
            end
        end
    end

    task automatic expect_val(string tag, int sel, logic [7:0] exp);
        exp_item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
        @(posedge clk);
        @(posedge clk);
    endtask

    task automatic wq(int n = 1);
        repeat (n * Q) @(posedge clk);
    endtask

    task automatic do_reset(logic mute_n, logic audio_n);
        strap_mute_n = mute_n;
        strap_audio_n = audio_n;
        scl_m = 1'b1; sda_m = 1'b1;
        rst = 1'b1;
        repeat (5) @(posedge clk);
        rst = 1'b0;
        repeat (10) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq(2);
    endtask

    task automatic send_byte(logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq();
            scl_m = 1'b1; wq(2);
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        last_ack = ~sda_bus; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(logic give_ack);
        logic [7:0] b;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq();
            scl_m = 1'b1; wq();
            b[i] = sda_bus; wq();
            scl_m = 1'b0; wq();
        end
        last_rd = b;
        sda_m = ~give_ack; wq();
        scl_m = 1'b1; wq(2);
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    initial begin
        do_reset(1'b0, 1'b0);
        // R11 / R6 / R7: reset values with both straps low
        expect_val("R11 oe after reset", 9, 8'h00);
        expect_val("R7 mode reset audio strap low", 0, 8'h02);
        expect_val("R6 route reset mute strap low", 1, 8'h00);
        expect_val("R7 gain12 strap low", 6, 8'h01);
        expect_val("R11 err hi reset", 2, 8'h00);
        expect_val("R11 aux reset", 4, 8'h00);

        // R1 / R3 / R8: write B4h, index 0, data 09h
        bus_start();
        send_byte(8'hB4); expect_val("R1 ack B4", 7, 8'h01);
        send_byte(8'h00); expect_val("R3 ack index", 7, 8'h01);
        send_byte(8'h09); expect_val("R3 ack data", 7, 8'h01);
        bus_stop();
        expect_val("R3 mode written", 0, 8'h09);
        expect_val("R8 port follows bit3", 5, 8'h01);
        expect_val("R7 gain follows bit1", 6, 8'h00);

        // R2: wrong strap bit and general call
        bus_start();
        send_byte(8'hB6); expect_val("R2 nack B6 when sel low", 7, 8'h00);
        send_byte(8'h00);
        send_byte(8'hFF);
        bus_stop();
        expect_val("R2 mode untouched", 0, 8'h09);
        bus_start();
        send_byte(8'h00); expect_val("R2 nack general call", 7, 8'h00);
        send_byte(8'h01);
        bus_stop();
        expect_val("R2 route untouched", 1, 8'h00);

        // R4: index 05h not acknowledged
        bus_start();
        send_byte(8'hB4);
        send_byte(8'h05); expect_val("R4 nack index 5", 7, 8'h00);
        send_byte(8'hEE);
        bus_stop();
        expect_val("R4 aux untouched", 4, 8'h00);
        expect_val("R4 mode untouched", 0, 8'h09);

        // R5: burst from index 3 wraps
        bus_start();
        send_byte(8'hB4);
        send_byte(8'h03);
        send_byte(8'h11);
        send_byte(8'h22);
        send_byte(8'h33);
        send_byte(8'h44); expect_val("R5 ack wrapped data", 7, 8'h01);
        bus_stop();
        expect_val("R5 reg3", 3, 8'h11);
        expect_val("R5 reg4", 4, 8'h22);
        expect_val("R5 wrap to reg0", 0, 8'h33);
        expect_val("R5 wrap to reg1", 1, 8'h44);
        expect_val("R5 reg2 untouched", 2, 8'h00);

        // R6: writing silence bit high
        bus_start();
        send_byte(8'hB4);
        send_byte(8'h01);
        send_byte(8'h08);
        bus_stop();
        expect_val("R6 silence set", 1, 8'h08);

        // R1 with addr_sel high, R9 read
        addr_sel = 1'b1;
        bus_start();
        send_byte(8'hB6); expect_val("R1 ack B6 sel high", 7, 8'h01);
        send_byte(8'h02);
        send_byte(8'h5A);
        bus_stop();
        expect_val("R1 reg2 written", 2, 8'h5A);
        bus_start();
        send_byte(8'hB7); expect_val("R9 ack read addr", 7, 8'h01);
        recv_byte(1'b1); expect_val("R9 first status", 8, 8'hA5);
        recv_byte(1'b1); expect_val("R9 second count", 8, 8'h3C);
        recv_byte(1'b0); expect_val("R9 third status", 8, 8'hA5);
        bus_stop();
        expect_val("R9 released", 9, 8'h00);

        // R10: STOP right after the index byte, then a fresh byte is an address
        bus_start();
        send_byte(8'hB6);
        send_byte(8'h02);
        bus_stop();
        expect_val("R10 reg2 kept", 2, 8'h5A);
        bus_start();
        send_byte(8'hB6); expect_val("R10 address after stop", 7, 8'h01);
        send_byte(8'h04);
        send_byte(8'h7E);
        // repeated START inside the burst
        bus_start();
        send_byte(8'hB6); expect_val("R10 ack after rep start", 7, 8'h01);
        send_byte(8'h03);
        send_byte(8'h99);
        bus_stop();
        expect_val("R10 reg4 kept", 4, 8'h7E);
        expect_val("R10 reg3 new", 3, 8'h99);
        expect_val("R10 reg0 untouched", 0, 8'h33);

        // R6 / R7 with both straps high
        do_reset(1'b1, 1'b1);
        expect_val("R7 mode reset audio strap high", 0, 8'h00);
        expect_val("R6 route reset mute strap high", 1, 8'h08);
        expect_val("R7 gain12 strap high", 6, 8'h00);
        expect_val("R11 lo limit reset", 3, 8'h00);

        repeat (4) @(posedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule